// File: doc/BRIEF.md
# DDR Burst Command Sequencer

This block sits between user logic and the user side of a DDR2 memory controller. One start pulse carries a base address, a number of four-word bursts and a direction. The block then pushes one command per burst into the controller's command/address FIFO. The first address is the base address and each later address is 4 higher. For writes it also fills the write-data FIFO with a counter pattern that can be checked on readback. For reads it counts the words that come back.

The memory moves data on both clock edges, so every burst of four words fills two controller clocks of data: two words per clock.

- **Write pacing.** A write command and its first data pair leave in the same cycle. The second pair leaves on a later cycle. Write commands therefore come at most every second clock.
- **Read pacing.** A read command can leave on every clock.
- **Backpressure.** Almost-full flags from both FIFOs hold the matching pushes off. No address is skipped or repeated.
- **Completion.** A one-cycle done pulse ends each transfer.

Top module: `ddr_burst_seq`

## Requirements
- R1: While reset is asserted and while no transfer is active, `cmd_wr_en` and `wd_wr_en` are 0 and `busy` and `done` are 0. `busy` is 1 from the cycle after an accepted start until the cycle `done` is 1.
- R2: A write transfer of N bursts pushes exactly N commands with code 3'b000. The address of command i is the base address plus 4*i, modulo 2^31.
- R3: Each write command is pushed in the same cycle as the first data pair of its burst. The second pair follows on a later cycle, and no command is pushed in the cycle right after a write command. Without backpressure, write commands are exactly two cycles apart.
- R4: Write data pair j belongs to burst i = j/2 and has half-position h = j%2. Its low 32 bits carry the word {i[29:0], h, 1'b0}. Its high 32 bits carry the word {i[29:0], h, 1'b1}. Burst index i counts from 0.
- R5: A read transfer of N bursts pushes exactly N commands with code 3'b001. Their addresses are the base address plus 4*i. Without backpressure the commands go out on N consecutive cycles, and no write data is pushed.
- R6: No command is pushed in a cycle where `cmd_afull` is 1. After backpressure the address sequence continues with no gap and no repeat.
- R7: No write data is pushed in a cycle where `wd_afull` is 1. A write command is also held back in that cycle, so that it still leaves together with its first data pair.
- R8: A write transfer ends with `done` high for one cycle, in the cycle after its last data pair was pushed. `busy` is 0 in that same cycle.
- R9: Each cycle with `rd_valid` high returns two words. A read transfer ends with `done` high for one cycle, in the cycle after the returned-word count reaches 4*N.
- R10: A start pulse while `busy` is 1 is ignored. The running transfer's commands, data and done timing are unchanged.
- R11: A start pulse with a burst count of 0 is ignored. No push follows, and `busy` and `done` stay 0.
- R12: `rd_valid` pulses while no read transfer is active are not counted. They do not shift the done timing of a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle transfer request |
| dir_rd | input | 1 | Direction of the request: 1 read, 0 write |
| base_addr | input | 31 | Address of the first burst |
| burst_cnt | input | 16 | Number of four-word bursts |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_wr_en | output | 1 | Push strobe for the command/address FIFO |
| cmd_code | output | 3 | Command code: 000 write, 001 read |
| cmd_addr | output | 31 | Command address |
| cmd_afull | input | 1 | Command FIFO almost full |
| wd_wr_en | output | 1 | Push strobe for the write-data FIFO |
| wd_data | output | 64 | Two data words: the earlier word in the low half |
| wd_afull | input | 1 | Write-data FIFO almost full |
| rd_valid | input | 1 | Read return beat carrying two words |

## Verification
The hardest situation to reach is a write burst that stalls between its two data pairs. It must resume with the same burst index and the same address, while the other almost-full flag changes on unrelated cycles. The bench drives the two almost-full flags from periodic patterns with different, coprime periods. This lines stalls up against both halves of many bursts in turn, and every pushed command and data pair is logged for comparison with the address and pattern formulas. Read completion is exercised with a responder that starts late and leaves gaps in the returns, and with stray return beats sent before the read.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WR       = 2'd1,
    ST_RD_ISSUE = 2'd2,
    ST_RD_WAIT  = 2'd3
  } seq_state_t;

  localparam logic [2:0] CMD_WRITE = 3'b000;
  localparam logic [2:0] CMD_READ  = 3'b001;

  localparam int unsigned BURST_WORDS    = 4;
  localparam int unsigned WORDS_PER_BEAT = 2;
endpackage

// File: rtl/seq_addr_step.sv
module seq_addr_step #(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  idx
);
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  idx_d;

  always_comb begin
    addr_d = addr;
    idx_d  = idx;
    if (load) begin
      addr_d = base;
      idx_d  = '0;
    end else if (adv) begin
      addr_d = addr + ADDR_W'(STEP);
      idx_d  = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      idx  <= '0;
    end else if (load || adv) begin
      addr <= addr_d;
      idx  <= idx_d;
    end
  end
endmodule

// File: rtl/seq_wpattern.sv
module seq_wpattern #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int NWORDS = 2
) (
  input  logic [CNT_W-1:0]         idx,
  input  logic                     half,
  output logic [NWORDS*DATA_W-1:0] pair
);
  localparam int IDX_W = DATA_W - 2;

  logic [IDX_W-1:0] idx_ext;
  assign idx_ext = IDX_W'(idx);

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam logic POS_LO = 1'(k);
    assign pair[k*DATA_W +: DATA_W] = {idx_ext, half, POS_LO};
  end
endmodule

// File: rtl/seq_ret_count.sv
module seq_ret_count #(
  parameter int CNT_W    = 16,
  parameter int PER_BEAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic [CNT_W+1:0] target,
  output logic             reached
);
  logic [CNT_W+1:0] words_q;
  logic [CNT_W+1:0] words_d;

  assign words_d = clear ? '0 : words_q + (CNT_W+2)'(PER_BEAT);
  assign reached = beat && (words_q + (CNT_W+2)'(PER_BEAT) >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
    end else if (clear || beat) begin
      words_q <= words_d;
    end
  end
endmodule

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq
  import ddr_seq_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic                                dir_rd,
  input  logic [ADDR_W-1:0]                   base_addr,
  input  logic [CNT_W-1:0]                    burst_cnt,
  output logic                                busy,
  output logic                                done,
  output logic                                cmd_wr_en,
  output logic [2:0]                          cmd_code,
  output logic [ADDR_W-1:0]                   cmd_addr,
  input  logic                                cmd_afull,
  output logic                                wd_wr_en,
  output logic [WORDS_PER_BEAT*DATA_W-1:0]    wd_data,
  input  logic                                wd_afull,
  input  logic                                rd_valid
);
  localparam int TGT_W = CNT_W + 2;

  seq_state_t       st_q, st_d;
  logic             half_q, half_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic             done_q, done_d;

  logic             accept;
  logic             last_burst;
  logic             wr_go0, wr_go1, rd_go;
  logic             adv;
  logic             ret_en, ret_hit;
  logic [CNT_W-1:0] idx;
  logic [TGT_W-1:0] target_words;

  assign accept     = (st_q == ST_IDLE) && start && (burst_cnt != '0);
  assign last_burst = (idx == total_q - 1'b1);

  assign wr_go0 = (st_q == ST_WR) && !half_q && !cmd_afull && !wd_afull;
  assign wr_go1 = (st_q == ST_WR) &&  half_q && !wd_afull;
  assign rd_go  = (st_q == ST_RD_ISSUE) && !cmd_afull;
  assign adv    = wr_go1 || rd_go;

  assign ret_en       = (st_q == ST_RD_ISSUE) || (st_q == ST_RD_WAIT);
  assign target_words = {total_q, 2'b00};

  seq_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(BURST_WORDS)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .base  (base_addr),
    .adv   (adv),
    .addr  (cmd_addr),
    .idx   (idx)
  );

  seq_wpattern #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NWORDS(WORDS_PER_BEAT)) u_pat (
    .idx  (idx),
    .half (half_q),
    .pair (wd_data)
  );

  seq_ret_count #(.CNT_W(CNT_W), .PER_BEAT(WORDS_PER_BEAT)) u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .beat    (rd_valid && ret_en),
    .target  (target_words),
    .reached (ret_hit)
  );

  always_comb begin
    st_d    = st_q;
    half_d  = half_q;
    total_d = total_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = dir_rd ? ST_RD_ISSUE : ST_WR;
          total_d = burst_cnt;
          half_d  = 1'b0;
        end
      end
      ST_WR: begin
        if (wr_go0) begin
          half_d = 1'b1;
        end else if (wr_go1) begin
          half_d = 1'b0;
          if (last_burst) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      ST_RD_ISSUE: begin
        if (rd_go && last_burst) begin
          st_d = ST_RD_WAIT;
        end
        if (ret_hit) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_RD_WAIT: begin
        if (ret_hit) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      half_q  <= 1'b0;
      total_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      half_q  <= half_d;
      total_q <= total_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign cmd_wr_en = wr_go0 || rd_go;
  assign cmd_code  = (st_q == ST_WR) ? CMD_WRITE : CMD_READ;
  assign wd_wr_en  = wr_go0 || wr_go1;
endmodule

// File: rtl/ddr_burst_seq_chk.sv
module ddr_burst_seq_chk #(
  parameter int ADDR_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              cmd_wr_en,
  input logic [2:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_afull,
  input logic              wd_wr_en,
  input logic              wd_afull
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (!busy) begin
      seen_q <= 1'b0;
    end else if (cmd_wr_en) begin
      seen_q <= 1'b1;
      prev_q <= cmd_addr;
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_wr_en && !wd_wr_en)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && seen_q) |-> (cmd_addr == prev_q + ADDR_W'(4))); // R2

  AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && cmd_code == 3'b000) |=> !cmd_wr_en); // R3

  AST_WR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && cmd_code == 3'b000) |-> wd_wr_en); // R3

  AST_RD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && cmd_code == 3'b001) |-> !wd_wr_en); // R5

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_afull |-> !cmd_wr_en); // R6

  AST_WD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wd_afull |-> !wd_wr_en); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind ddr_burst_seq ddr_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ddr_burst_seq.sv
`timescale 1ns/1ps
module sim_ddr_burst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 256;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        dir_rd;
  logic [30:0] base_addr;
  logic [15:0] burst_cnt;
  logic        busy, done;
  logic        cmd_wr_en;
  logic [2:0]  cmd_code;
  logic [30:0] cmd_addr;
  logic        cmd_afull;
  logic        wd_wr_en;
  logic [63:0] wd_data;
  logic        wd_afull;
  logic        rd_valid;

  ddr_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd),
    .base_addr(base_addr), .burst_cnt(burst_cnt), .busy(busy), .done(done),
    .cmd_wr_en(cmd_wr_en), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_afull(cmd_afull), .wd_wr_en(wd_wr_en), .wd_data(wd_data),
    .wd_afull(wd_afull), .rd_valid(rd_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int          n_cmd, n_wd, n_done, n_rd, done_cyc, last_rd_cyc;
  int          viol_c, viol_w;
  logic [2:0]  code_log [LOGN];
  logic [30:0] addr_log [LOGN];
  int          ccyc_log [LOGN];
  logic [63:0] wd_log   [LOGN];
  int          wcyc_log [LOGN];

  bit cmode, wmode, gap, stray;
  int pending, first_rd;
  bit rd_seen;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=%0d expected=<150000 cycles", cyc);
    summary();
    $finish;
  end

  // Input drive at the falling edge, then output sampling once settled.
  always @(negedge clk) begin
    cmd_afull = cmode && ((cyc % 5) < 2);
    wd_afull  = wmode && ((cyc % 7) == 3);
    rd_valid  = stray || (rd_seen && pending > 0 && cyc >= first_rd + 3 &&
                          !(gap && (cyc % 3) == 0));
    #2;
    if (cmd_wr_en) begin
      if (cmd_afull) viol_c++;
      if (n_cmd < LOGN) begin
        code_log[n_cmd] = cmd_code;
        addr_log[n_cmd] = cmd_addr;
        ccyc_log[n_cmd] = cyc;
      end
      n_cmd++;
      if (cmd_code == 3'b001) begin
        pending += 4;
        if (!rd_seen) begin
          rd_seen  = 1'b1;
          first_rd = cyc;
        end
      end
    end
    if (wd_wr_en) begin
      if (wd_afull) viol_w++;
      if (n_wd < LOGN) begin
        wd_log[n_wd]   = wd_data;
        wcyc_log[n_wd] = cyc;
      end
      n_wd++;
    end
    if (rd_valid && !stray && pending > 0) begin
      pending -= 2;
      n_rd++;
      last_rd_cyc = cyc;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_cmd = 0; n_wd = 0; n_done = 0; n_rd = 0; done_cyc = -1; last_rd_cyc = -1;
    viol_c = 0; viol_w = 0; pending = 0; rd_seen = 1'b0; first_rd = 0;
  endtask

  task automatic pulse_start(bit rd, logic [30:0] b, logic [15:0] n);
    @(negedge clk);
    start = 1'b1; dir_rd = rd; base_addr = b; burst_cnt = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 4000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    #3;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; dir_rd = 1'b0; base_addr = '0; burst_cnt = '0;
    cmode = 0; wmode = 0; gap = 0; stray = 0;
    clear_logs();
    repeat (3) @(negedge clk);
    #3;
    chk(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
    chk(!cmd_wr_en && !wd_wr_en, "R1", "strobes in reset", {cmd_wr_en, wd_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #3;
    chk(!busy && !cmd_wr_en && !wd_wr_en, "R1", "idle after reset",
        {busy, cmd_wr_en, wd_wr_en}, 0);
  endtask

  task automatic t_write(logic [30:0] b, int n, bit cm, bit wm, bit extra);
    int bad_code = 0, bad_addr = 0, bad_pat = 0, bad_pair = 0, bad_space = 0;
    clear_logs();
    cmode = cm; wmode = wm;
    pulse_start(1'b0, b, 16'(n));
    if (extra) begin
      @(negedge clk);
      pulse_start(1'b1, b + 31'd1000, 16'd2); // R10: must be ignored
    end
    wait_done();
    cmode = 0; wmode = 0;
    chk(n_cmd == n, "R2", "write command count", n_cmd, n);
    for (int i = 0; i < n && i < LOGN; i++) begin
      if (code_log[i] != 3'b000) bad_code++;
      if (addr_log[i] != 31'(b + 31'(4 * i))) bad_addr++;
      if (i > 0 && (ccyc_log[i] - ccyc_log[i-1]) < 2) bad_space++;
      if (i > 0 && !cm && !wm && (ccyc_log[i] - ccyc_log[i-1]) != 2) bad_space++;
      if (wcyc_log[2*i] != ccyc_log[i]) bad_pair++;
    end
    chk(bad_code == 0, "R2", "write command codes", bad_code, 0);
    chk(bad_addr == 0, "R6", "write address sequence base+4i", bad_addr, 0);
    chk(bad_space == 0, "R3", "write command spacing", bad_space, 0);
    chk(bad_pair == 0, "R3", "command with first data pair", bad_pair, 0);
    chk(n_wd == 2 * n, "R4", "data pair count", n_wd, 2 * n);
    for (int j = 0; j < 2 * n && j < LOGN; j++) begin
      logic [31:0] lo = 32'((j / 2) * 4 + (j % 2) * 2);
      if (wd_log[j] != {lo | 32'd1, lo}) bad_pat++;
    end
    chk(bad_pat == 0, "R4", "data pattern", bad_pat, 0);
    chk(viol_c == 0, "R6", "command push under cmd_afull", viol_c, 0);
    chk(viol_w == 0, "R7", "data push under wd_afull", viol_w, 0);
    chk(n_done == 1, "R8", "write done pulses", n_done, 1);
    chk(done_cyc == wcyc_log[2 * n - 1] + 1, "R8", "write done cycle",
        done_cyc, wcyc_log[2 * n - 1] + 1);
    chk(!busy, "R8", "busy after write", busy, 0);
    if (extra) chk(n_cmd == n && bad_code == 0, "R10", "start while busy ignored", n_cmd, n);
  endtask

  task automatic t_read(logic [30:0] b, int n, bit cm, bit gp);
    int bad_code = 0, bad_addr = 0, bad_space = 0;
    clear_logs();
    cmode = cm; gap = gp;
    pulse_start(1'b1, b, 16'(n));
    wait_done();
    cmode = 0; gap = 0;
    chk(n_cmd == n, "R5", "read command count", n_cmd, n);
    for (int i = 0; i < n && i < LOGN; i++) begin
      if (code_log[i] != 3'b001) bad_code++;
      if (addr_log[i] != 31'(b + 31'(4 * i))) bad_addr++;
      if (i > 0 && !cm && (ccyc_log[i] - ccyc_log[i-1]) != 1) bad_space++;
    end
    chk(bad_code == 0, "R5", "read command codes", bad_code, 0);
    chk(bad_addr == 0, "R5", "read address sequence", bad_addr, 0);
    chk(bad_space == 0, "R5", "read commands back to back", bad_space, 0);
    chk(n_wd == 0, "R5", "no write data during read", n_wd, 0);
    chk(viol_c == 0, "R6", "read push under cmd_afull", viol_c, 0);
    chk(n_rd == 2 * n, "R9", "return beats", n_rd, 2 * n);
    chk(n_done == 1, "R9", "read done pulses", n_done, 1);
    chk(done_cyc == last_rd_cyc + 1, "R9", "read done cycle", done_cyc, last_rd_cyc + 1);
  endtask

  task automatic t_zero();
    clear_logs();
    pulse_start(1'b0, 31'h100, 16'd0);
    repeat (4) @(negedge clk);
    #3;
    chk(n_cmd == 0 && n_wd == 0, "R11", "pushes after zero-count start", n_cmd + n_wd, 0);
    chk(!busy && n_done == 0, "R11", "busy/done after zero-count start", busy + n_done, 0);
  endtask

  task automatic t_stray();
    clear_logs();
    @(negedge clk);
    stray = 1'b1;
    repeat (5) @(negedge clk);
    stray = 1'b0;
    #3;
    chk(!busy && n_done == 0, "R12", "stray returns while idle", busy + n_done, 0);
    t_read(31'h0000_0040, 3, 1'b0, 1'b0); // R12: done must match only real returns
  endtask

  initial begin
    t_reset();
    t_write(31'h0000_0000, 4, 1'b0, 1'b0, 1'b0);
    t_write(31'h0000_1000, 6, 1'b1, 1'b1, 1'b0);
    t_write(31'h7FFF_FFF8, 3, 1'b0, 1'b1, 1'b1);
    t_read(31'h0000_2000, 4, 1'b0, 1'b0);
    t_read(31'h0000_3000, 5, 1'b1, 1'b1);
    t_zero();
    t_stray();
    t_write(31'h0000_0010, 1, 1'b1, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule